// File: doc/BRIEF.md
# Split 16-bit Constant Register Loader

This block holds a register file of sixteen 32-bit registers and fills it with constants that arrive as 16-bit immediates. A full 32-bit value takes two operations. A low operation sign-extends its immediate across the whole destination register. A high operation replaces only the upper half and keeps the lower half the register already holds. Because the low operation overwrites the upper half with copies of the immediate's sign bit, a full constant is built only when the low operation comes first and the high operation follows.

Two write slots can issue in the same cycle. Each slot carries an enable, an operation select, a destination index and an immediate. Writes take effect at the rising clock edge. An asynchronous combinational read port shows any register to the surrounding logic or to a testbench. When the two slots target the same register with opposite operations in one cycle, the block refuses both writes to that register and raises a one-cycle error flag.

Top module: `const_loader`

## Requirements
- R1: After reset every register reads 0x00000000 and `clash` is low.
- R2: A low operation (`sN_hi`=0) writes the immediate to bits 15:0 of the destination and copies immediate bit 15 into bits 31:16, so 0xFABC gives 0xFFFFFABC and 0x1234 gives 0x00001234.
- R3: A high operation (`sN_hi`=1) writes the immediate to bits 31:16 and leaves bits 15:0 unchanged, so a high load of 0x1234 into 0x87654321 gives 0x12344321.
- R4: Low 0xFABC followed by high 0x1234 yields 0x1234FABC. High 0x1234 followed by low 0xFABC yields 0xFFFFFABC.
- R5: A write issued in one cycle shows on `rd_data` from the cycle after its clock edge, and `rd_data` follows `rd_idx` without a clock.
- R6: Both slots enabled with different destinations update both registers at the same edge.
- R7: Both slots enabled with the same destination and the same operation write the value from slot 1.
- R8: Both slots enabled with the same destination and opposite operations leave that register unchanged, and `clash` is high for the cycle after that edge. In every other case `clash` is low.
- R9: A slot whose enable is low changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| s0_en | input | 1 | Slot 0 write enable |
| s0_hi | input | 1 | Slot 0 operation: 0 low sign-extend, 1 high half |
| s0_dst | input | 4 | Slot 0 destination register index |
| s0_imm | input | 16 | Slot 0 immediate |
| s1_en | input | 1 | Slot 1 write enable |
| s1_hi | input | 1 | Slot 1 operation: 0 low sign-extend, 1 high half |
| s1_dst | input | 4 | Slot 1 destination register index |
| s1_imm | input | 16 | Slot 1 immediate |
| rd_idx | input | 4 | Read port register index |
| rd_data | output | 32 | Contents of the register chosen by `rd_idx` |
| clash | output | 1 | High one cycle after an opposite-operation same-register collision |

## Verification
The assertions assume that every slot input is stable and known around each rising edge. They also assume that a disabled slot's other fields may hold any value without effect. The bench changes inputs only at falling edges and drops both enables after each issued operation. Each register therefore has a clean one-cycle window in which the bench reads it. The bench drives known values on disabled slots' destination and immediate fields, so that a leak through a missing enable would show as a changed register.

// File: rtl/const_loader.sv
module const_loader #(
  parameter int REGS = 16,
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s0_en,
  input  logic                    s0_hi,
  input  logic [$clog2(REGS)-1:0] s0_dst,
  input  logic [IMMW-1:0]         s0_imm,
  input  logic                    s1_en,
  input  logic                    s1_hi,
  input  logic [$clog2(REGS)-1:0] s1_dst,
  input  logic [IMMW-1:0]         s1_imm,
  input  logic [$clog2(REGS)-1:0] rd_idx,
  output logic [XLEN-1:0]         rd_data,
  output logic                    clash
);
  localparam int AW   = $clog2(REGS);
  localparam int KEEP = XLEN - IMMW;

  logic [XLEN-1:0] rf [REGS];

  wire same_dst  = s0_en && s1_en && (s0_dst == s1_dst);
  wire clash_now = same_dst && (s0_hi != s1_hi);

  function automatic logic [XLEN-1:0] merge(input logic hi, input logic [IMMW-1:0] imm,
                                            input logic [XLEN-1:0] old);
    merge = hi ? {imm, old[KEEP-1:0]} : {{KEEP{imm[IMMW-1]}}, imm};
  endfunction

  for (genvar g = 0; g < REGS; g++) begin : g_reg
    wire hit0 = s0_en && (s0_dst == AW'(g));
    wire hit1 = s1_en && (s1_dst == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rf[g] <= '0;
      else if (!(clash_now && hit0)) begin
        if (hit1)      rf[g] <= merge(s1_hi, s1_imm, rf[g]);
        else if (hit0) rf[g] <= merge(s0_hi, s0_imm, rf[g]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clash <= 1'b0;
    else        clash <= clash_now;
  end

  assign rd_data = rf[rd_idx];
endmodule

// File: rtl/const_loader_chk.sv
module const_loader_chk #(
  parameter int REGS = 16,
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    s0_en,
  input logic                    s0_hi,
  input logic [$clog2(REGS)-1:0] s0_dst,
  input logic [IMMW-1:0]         s0_imm,
  input logic                    s1_en,
  input logic                    s1_hi,
  input logic [$clog2(REGS)-1:0] s1_dst,
  input logic [IMMW-1:0]         s1_imm,
  input logic                    clash,
  input logic [XLEN-1:0]         rf [REGS]
);
  localparam int KEEP = XLEN - IMMW;

  wire only0 = s0_en && !(s1_en && s1_dst == s0_dst);
  wire opp   = s0_en && s1_en && (s0_dst == s1_dst) && (s0_hi != s1_hi);

  // R2
  low_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only0 && !s0_hi |=> rf[$past(s0_dst)] ==
      {{KEEP{$past(s0_imm[IMMW-1])}}, $past(s0_imm)});

  // R3
  high_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    only0 && s0_hi |=> rf[$past(s0_dst)][XLEN-1:KEEP] == $past(s0_imm) &&
      rf[$past(s0_dst)][KEEP-1:0] == $past(rf[s0_dst][KEEP-1:0]));

  // R7
  slot1_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_en && !s1_hi && !(s0_en && s0_dst == s1_dst && s0_hi) |=>
      rf[$past(s1_dst)] == {{KEEP{$past(s1_imm[IMMW-1])}}, $past(s1_imm)});

  // R8
  clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opp |=> clash && rf[$past(s0_dst)] == $past(rf[s0_dst]));

  // R8
  clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !opp |=> !clash);
endmodule

bind const_loader const_loader_chk #(.REGS(REGS), .XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s0_en(s0_en), .s0_hi(s0_hi), .s0_dst(s0_dst), .s0_imm(s0_imm),
  .s1_en(s1_en), .s1_hi(s1_hi), .s1_dst(s1_dst), .s1_imm(s1_imm),
  .clash(clash), .rf(rf)
);

// File: tb/sim_const_loader.sv
module sim_const_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s0_en = 0, s0_hi = 0, s1_en = 0, s1_hi = 0;
  logic [3:0] s0_dst = 0, s1_dst = 0, rd_idx = 0;
  logic [15:0] s0_imm = 0, s1_imm = 0;
  logic [31:0] rd_data;
  logic clash;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  const_loader u0 (.clk(clk), .rst_n(rst_n),
    .s0_en(s0_en), .s0_hi(s0_hi), .s0_dst(s0_dst), .s0_imm(s0_imm),
    .s1_en(s1_en), .s1_hi(s1_hi), .s1_dst(s1_dst), .s1_imm(s1_imm),
    .rd_idx(rd_idx), .rd_data(rd_data), .clash(clash));

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(input string req, input logic [3:0] idx, input logic [31:0] exp);
    rd_idx = idx;
    #1;
    cmp(req, rd_data, exp);
  endtask

  task automatic issue(input logic e0, h0, input logic [3:0] d0, input logic [15:0] i0,
                       input logic e1, h1, input logic [3:0] d1, input logic [15:0] i1);
    @(negedge clk);
    s0_en = e0; s0_hi = h0; s0_dst = d0; s0_imm = i0;
    s1_en = e1; s1_hi = h1; s1_dst = d1; s1_imm = i1;
    @(negedge clk);
    s0_en = 0; s1_en = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) peek("R1 reg", 4'(i), 32'h0);
    cmp("R1 clash", {31'b0, clash}, 32'h0);
  endtask

  task automatic t_low();
    issue(1, 0, 4'd2, 16'hFABC, 0, 0, 4'd0, 16'h0);
    peek("R2 negative", 4'd2, 32'hFFFFFABC);
    issue(1, 0, 4'd3, 16'h1234, 0, 0, 4'd0, 16'h0);
    peek("R2 positive", 4'd3, 32'h00001234);
    peek("R5 read follows index", 4'd2, 32'hFFFFFABC);
  endtask

  task automatic t_high();
    issue(1, 0, 4'd4, 16'h4321, 0, 0, 4'd0, 16'h0);
    issue(1, 1, 4'd4, 16'h8765, 0, 0, 4'd0, 16'h0);
    peek("R3 build", 4'd4, 32'h87654321);
    issue(1, 1, 4'd4, 16'h1234, 0, 0, 4'd0, 16'h0);
    peek("R3 keep low", 4'd4, 32'h12344321);
  endtask

  task automatic t_order();
    issue(1, 0, 4'd5, 16'hFABC, 0, 0, 4'd0, 16'h0);
    issue(1, 1, 4'd5, 16'h1234, 0, 0, 4'd0, 16'h0);
    peek("R4 low then high", 4'd5, 32'h1234FABC);
    issue(1, 1, 4'd6, 16'h1234, 0, 0, 4'd0, 16'h0);
    issue(1, 0, 4'd6, 16'hFABC, 0, 0, 4'd0, 16'h0);
    peek("R4 high then low", 4'd6, 32'hFFFFFABC);
  endtask

  task automatic t_timing();
    @(negedge clk);
    rd_idx = 4'd7;
    s0_en = 1; s0_hi = 0; s0_dst = 4'd7; s0_imm = 16'h0055;
    #1;
    cmp("R5 before edge", rd_data, 32'h0);
    @(negedge clk);
    s0_en = 0;
    #1;
    cmp("R5 after edge", rd_data, 32'h00000055);
  endtask

  task automatic t_dual();
    issue(1, 0, 4'd8, 16'h8001, 1, 1, 4'd9, 16'h7FFF);
    peek("R6 slot0", 4'd8, 32'hFFFF8001);
    peek("R6 slot1", 4'd9, 32'h7FFF0000);
    issue(1, 0, 4'd10, 16'h1111, 1, 0, 4'd10, 16'h9999);
    peek("R7 low same", 4'd10, 32'hFFFF9999);
    issue(1, 1, 4'd10, 16'h2222, 1, 1, 4'd10, 16'h3333);
    peek("R7 high same", 4'd10, 32'h33339999);
  endtask

  task automatic t_clash();
    issue(1, 0, 4'd4, 16'hAAAA, 1, 1, 4'd4, 16'h5555);
    cmp("R8 flag", {31'b0, clash}, 32'h1);
    peek("R8 no write", 4'd4, 32'h12344321);
    @(negedge clk);
    cmp("R8 flag clears", {31'b0, clash}, 32'h0);
    issue(1, 1, 4'd11, 16'hAAAA, 1, 0, 4'd11, 16'h5555);
    cmp("R8 flag swapped", {31'b0, clash}, 32'h1);
    peek("R8 no write swapped", 4'd11, 32'h0);
    issue(1, 0, 4'd12, 16'h1, 1, 1, 4'd13, 16'h1);
    cmp("R8 no flag different dst", {31'b0, clash}, 32'h0);
  endtask

  task automatic t_disabled();
    issue(0, 0, 4'd5, 16'h0000, 0, 1, 4'd14, 16'hBEEF);
    peek("R9 slot0 off", 4'd5, 32'h1234FABC);
    peek("R9 slot1 off", 4'd14, 32'h0);
  endtask

  initial begin
    fork
      begin
        #20 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_low();
        t_high();
        t_order();
        t_timing();
        t_dual();
        t_clash();
        t_disabled();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule